// File: doc/BRIEF.md
# Cache-Line Write-Merge Buffer

This block sits between a word-wide target port and a memory port that moves nothing smaller than a whole line. The target port takes 32-bit reads and writes from an outside master. The memory port fetches and stores complete lines of `LINE_WORDS` words (128 bytes by default). The block holds one line at a time in a small single-port-read, byte-writable line store.

When a read arrives for a line that is not held, the block fetches the whole line and answers from its copy. When a write arrives for a line that is not held, the block also fetches the line first. It then folds each write into the copy under the byte enables. While a line is held, every access to it is served at one word per clock, with no memory traffic.

The held line is given up when an accepted beat carries the end-of-burst flag, or when an access names a different line. A modified line is first streamed back to memory as one full-line store. A line that was only read is dropped silently. Memory requests use a hold-until-grant handshake. Fill data arrives one word per valid beat, in word order. Write-back data leaves on consecutive cycles, also in word order.

Top module: `line_merge_buf`

## Requirements
- R1: After reset no line is held: `t_ready`, `t_rvalid`, `m_req` and `m_wb_valid` are all low.
- R2: A read to a line that is not held raises a memory request with `m_we` = 0 and `m_line` = `t_waddr[WADDR_W-1:5]`. Once the line has arrived, the read is accepted, and the addressed word appears on `t_rdata` with `t_rvalid` high in the cycle after acceptance.
- R3: The word within a line is chosen by `t_waddr[4:0]` (byte address bits 6:2), so words 0 through 31 of the fetched line are each reachable.
- R4: While a line fetch is outstanding, `t_ready` stays low and the master's request is held off.
- R5: Once a line is held, accesses to that line are accepted on every cycle with no wait state and no further memory request.
- R6: A write to a line that is not held fetches the line first. Bit i of `t_be` selects bits 8i+7:8i of `t_wdata` for merging. Bytes whose enable is 0 keep their fetched value in the line that is later written back.
- R7: An accepted beat with `t_last` = 1 on a line that has been written raises one request with `m_we` = 1. It is followed by exactly `LINE_WORDS` write-back beats on consecutive cycles, in word order 0 upward.
- R8: After an accepted beat with `t_last` = 1, the line is released. The next access, even to the same line, fetches it again.
- R9: A line that was only read is released without any write-back request.
- R10: When a modified line is held and an access names a different line, the last write-back beat of the old line comes before the fetch request for the new line is raised.
- R11: `m_req`, `m_we` and `m_line` stay steady from the cycle `m_req` rises until the cycle `m_gnt` is seen. `m_req` is low in the following cycle.
- R12: A read that follows writes to the same word within one held line returns the merged word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| t_valid | input | 1 | Master presents an access |
| t_write | input | 1 | 1 = write, 0 = read |
| t_waddr | input | WADDR_W | Word address (byte address bits above 1:0) |
| t_wdata | input | WORD_W | Write data |
| t_be | input | WORD_W/8 | Byte enables for writes |
| t_last | input | 1 | Final beat of the burst |
| t_ready | output | 1 | Access accepted this cycle when high with t_valid |
| t_rvalid | output | 1 | Read data valid (one cycle after acceptance) |
| t_rdata | output | WORD_W | Read data |
| m_req | output | 1 | Line transfer request, held until grant |
| m_we | output | 1 | 1 = line store, 0 = line fetch |
| m_line | output | WADDR_W-5 | Line address |
| m_gnt | input | 1 | Memory accepts the request |
| m_fill_valid | input | 1 | Fill word valid |
| m_fill_data | input | WORD_W | Fill word, in word order |
| m_wb_valid | output | 1 | Write-back word valid |
| m_wb_data | output | WORD_W | Write-back word, in word order |

## Verification
The bench targets several corner cases:
- Words 0 and 31 of a line, which a wrong index slice would swap or alias.
- Partial and all-zero byte enables, which a design that writes whole words would corrupt in the stored line.
- A read of a word written earlier in the same burst, which a read port returning stale data would get wrong.
- A write burst that crosses into another line, where a design that issues the new fetch early would overlap the write-back stream.
- Repeated read-only bursts, which must each refetch and never store; a design that retains the line or marks it dirty would show up in the request counts.

The memory model delays its grant, leaves a gap in the fill stream and flags any gap in the write-back stream. This catches handshake or beat-counting errors.

// File: rtl/lmb_pkg.sv
package lmb_pkg;

  typedef enum logic [2:0] {
    ST_READY    = 3'd0,
    ST_WB_REQ   = 3'd1,
    ST_WB       = 3'd2,
    ST_WB_END   = 3'd3,
    ST_FILL_REQ = 3'd4,
    ST_FILL     = 3'd5
  } lmb_state_e;

endpackage

// File: rtl/lmb_line_ram.sv
module lmb_line_ram #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int BYTES = WORD_W / 8
) (
  input  logic              clk,
  input  logic [BYTES-1:0]  we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);

  // one byte-wide array per lane so that each maps onto a RAM with its own write enable
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] q;

    always_ff @(posedge clk) begin
      if (we[b]) mem[waddr] <= wdata[8*b +: 8];
      if (re)    q <= mem[raddr];
    end

    assign rdata[8*b +: 8] = q;
  end

endmodule

// File: rtl/lmb_ctrl.sv
module lmb_ctrl
  import lmb_pkg::*;
#(
  parameter int LINE_WORDS = 32,
  parameter int TAG_W      = 25,
  parameter int BYTES      = 4,
  localparam int OFF_W     = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              t_valid,
  input  logic              t_write,
  input  logic [TAG_W-1:0]  t_tag,
  input  logic [OFF_W-1:0]  t_word,
  input  logic [BYTES-1:0]  t_be,
  input  logic              t_last,
  output logic              t_ready,
  output logic              t_rvalid,
  output logic              m_req,
  output logic              m_we,
  output logic [TAG_W-1:0]  m_line,
  input  logic              m_gnt,
  input  logic              m_fill_valid,
  output logic              m_wb_valid,
  output logic [BYTES-1:0]  ram_we,
  output logic [OFF_W-1:0]  ram_waddr,
  output logic              ram_fill,
  output logic              ram_re,
  output logic [OFF_W-1:0]  ram_raddr
);

  localparam logic [OFF_W-1:0] LAST_IDX = OFF_W'(LINE_WORDS - 1);

  lmb_state_e       state;
  logic             buf_valid;
  logic             buf_dirty;
  logic [TAG_W-1:0] buf_tag;
  logic [OFF_W-1:0] cnt;
  logic             hit;
  logic             acc;

  assign hit     = buf_valid && (buf_tag == t_tag);
  assign t_ready = (state == ST_READY) && hit;
  assign acc     = t_ready && t_valid;

  // line store port steering: fill beats win the write port, write-back owns the read port
  always_comb begin
    ram_fill  = (state == ST_FILL);
    ram_we    = '0;
    ram_waddr = t_word;
    if (state == ST_FILL) begin
      ram_waddr = cnt;
      if (m_fill_valid) ram_we = '1;
    end else if (acc && t_write) begin
      ram_we = t_be;
    end
    ram_re    = (state == ST_WB) || (acc && !t_write);
    ram_raddr = (state == ST_WB) ? cnt : t_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_READY;
      buf_valid  <= 1'b0;
      buf_dirty  <= 1'b0;
      buf_tag    <= '0;
      cnt        <= '0;
      m_req      <= 1'b0;
      m_we       <= 1'b0;
      m_line     <= '0;
      m_wb_valid <= 1'b0;
      t_rvalid   <= 1'b0;
    end else begin
      t_rvalid   <= acc && !t_write;
      m_wb_valid <= (state == ST_WB);
      unique case (state)
        ST_READY: begin
          if (t_valid) begin
            if (hit) begin
              if (t_write) buf_dirty <= 1'b1;
              if (t_last) begin
                if (t_write || buf_dirty) begin
                  state  <= ST_WB_REQ;
                  m_req  <= 1'b1;
                  m_we   <= 1'b1;
                  m_line <= buf_tag;
                end else begin
                  buf_valid <= 1'b0;
                end
              end
            end else if (buf_valid && buf_dirty) begin
              state  <= ST_WB_REQ;
              m_req  <= 1'b1;
              m_we   <= 1'b1;
              m_line <= buf_tag;
            end else begin
              state     <= ST_FILL_REQ;
              buf_valid <= 1'b0;
              m_req     <= 1'b1;
              m_we      <= 1'b0;
              m_line    <= t_tag;
            end
          end
        end
        ST_WB_REQ: begin
          if (m_gnt) begin
            m_req <= 1'b0;
            cnt   <= '0;
            state <= ST_WB;
          end
        end
        ST_WB: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_IDX) state <= ST_WB_END;
        end
        ST_WB_END: begin
          buf_valid <= 1'b0;
          buf_dirty <= 1'b0;
          state     <= ST_READY;
        end
        ST_FILL_REQ: begin
          if (m_gnt) begin
            m_req <= 1'b0;
            cnt   <= '0;
            state <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (m_fill_valid) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_IDX) begin
              buf_valid <= 1'b1;
              buf_dirty <= 1'b0;
              buf_tag   <= m_line;
              state     <= ST_READY;
            end
          end
        end
        default: state <= ST_READY;
      endcase
    end
  end

  // consecutive write-back beat counter used by the length check
  logic [OFF_W:0] wb_run;
  always_ff @(posedge clk) begin
    if (rst)             wb_run <= '0;
    else if (m_wb_valid) wb_run <= wb_run + 1'b1;
    else                 wb_run <= '0;
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_gnt) |=> (m_req && $stable(m_line) && $stable(m_we)));

  // R11
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_gnt) |=> !m_req);

  // R10
  req_wb_excl_chk: assert property (@(posedge clk) disable iff (rst)
    m_wb_valid |-> !m_req);

  // R4
  no_ready_in_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req || state == ST_FILL) |-> !t_ready);

  // R7
  wb_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(m_wb_valid) |-> (wb_run == (OFF_W+1)'(LINE_WORDS)));

  // R9
  clean_no_store_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_we) |-> buf_dirty);

  // R2
  read_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (t_valid && t_ready && !t_write) |=> t_rvalid);

endmodule

// File: rtl/line_merge_buf.sv
module line_merge_buf #(
  parameter int WADDR_W    = 30,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 32,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int TAG_W     = WADDR_W - OFF_W,
  localparam int BYTES     = WORD_W / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               t_valid,
  input  logic               t_write,
  input  logic [WADDR_W-1:0] t_waddr,
  input  logic [WORD_W-1:0]  t_wdata,
  input  logic [BYTES-1:0]   t_be,
  input  logic               t_last,
  output logic               t_ready,
  output logic               t_rvalid,
  output logic [WORD_W-1:0]  t_rdata,
  output logic               m_req,
  output logic               m_we,
  output logic [TAG_W-1:0]   m_line,
  input  logic               m_gnt,
  input  logic               m_fill_valid,
  input  logic [WORD_W-1:0]  m_fill_data,
  output logic               m_wb_valid,
  output logic [WORD_W-1:0]  m_wb_data
);

  logic [BYTES-1:0]  ram_we;
  logic [OFF_W-1:0]  ram_waddr;
  logic              ram_fill;
  logic              ram_re;
  logic [OFF_W-1:0]  ram_raddr;
  logic [WORD_W-1:0] ram_wdata;
  logic [WORD_W-1:0] ram_q;

  lmb_ctrl #(
    .LINE_WORDS (LINE_WORDS),
    .TAG_W      (TAG_W),
    .BYTES      (BYTES)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .t_valid      (t_valid),
    .t_write      (t_write),
    .t_tag        (t_waddr[WADDR_W-1:OFF_W]),
    .t_word       (t_waddr[OFF_W-1:0]),
    .t_be         (t_be),
    .t_last       (t_last),
    .t_ready      (t_ready),
    .t_rvalid     (t_rvalid),
    .m_req        (m_req),
    .m_we         (m_we),
    .m_line       (m_line),
    .m_gnt        (m_gnt),
    .m_fill_valid (m_fill_valid),
    .m_wb_valid   (m_wb_valid),
    .ram_we       (ram_we),
    .ram_waddr    (ram_waddr),
    .ram_fill     (ram_fill),
    .ram_re       (ram_re),
    .ram_raddr    (ram_raddr)
  );

  assign ram_wdata = ram_fill ? m_fill_data : t_wdata;

  lmb_line_ram #(
    .WORD_W (WORD_W),
    .DEPTH  (LINE_WORDS)
  ) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_q)
  );

  // the store's registered output feeds both data outputs; their valids never overlap
  assign t_rdata   = ram_q;
  assign m_wb_data = ram_q;

endmodule

// File: tb/line_merge_buf_tb.sv
module line_merge_buf_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LW         = 32;
  localparam int NLINES     = 8;
  localparam int GNT_DLY    = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        t_valid = 1'b0, t_write = 1'b0, t_last = 1'b0;
  logic [29:0] t_waddr = '0;
  logic [31:0] t_wdata = '0;
  logic [3:0]  t_be = '0;
  logic        t_ready, t_rvalid;
  logic [31:0] t_rdata;
  logic        m_req, m_we, m_gnt, m_fill_valid, m_wb_valid;
  logic [24:0] m_line;
  logic [31:0] m_fill_data, m_wb_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_merge_buf u_dut (
    .clk(clk), .rst(rst), .t_valid(t_valid), .t_write(t_write), .t_waddr(t_waddr),
    .t_wdata(t_wdata), .t_be(t_be), .t_last(t_last), .t_ready(t_ready),
    .t_rvalid(t_rvalid), .t_rdata(t_rdata), .m_req(m_req), .m_we(m_we),
    .m_line(m_line), .m_gnt(m_gnt), .m_fill_valid(m_fill_valid),
    .m_fill_data(m_fill_data), .m_wb_valid(m_wb_valid), .m_wb_data(m_wb_data)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic [31:0] lmem    [NLINES*LW];
  logic [31:0] exp_mem [NLINES*LW];
  int fills = 0, wbs = 0, wb_busy = 0;
  int req_hold_err = 0, rdy_fill_err = 0, wb_gap_err = 0;
  int wb_done_cyc = 0, fill_req_cyc = 0;
  int last_fill_line = -1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // memory model: delayed grant, fill with one idle gap, write-back capture
  initial begin
    m_gnt = 1'b0; m_fill_valid = 1'b0; m_fill_data = '0;
    forever begin
      @(negedge clk);
      if (!rst && m_req) begin
        automatic int  rq_line = int'(m_line[2:0]);
        automatic bit  rq_we   = m_we;
        if (!rq_we) begin
          fill_req_cyc   = cyc;
          last_fill_line = int'(m_line);
        end
        for (int d = 0; d < GNT_DLY; d++) begin
          @(negedge clk);
          if (!m_req || int'(m_line[2:0]) != rq_line || m_we != rq_we) req_hold_err++;
        end
        m_gnt = 1'b1;
        @(negedge clk);
        m_gnt = 1'b0;
        if (m_req) req_hold_err++;
        if (!rq_we) begin
          fills++;
          for (int i = 0; i < LW; i++) begin
            if (i == 3) @(negedge clk);
            m_fill_valid = 1'b1;
            m_fill_data  = lmem[rq_line*LW + i];
            if (t_ready) rdy_fill_err++;
            @(negedge clk);
            m_fill_valid = 1'b0;
          end
        end else begin
          automatic int got = 0;
          automatic bit started = 1'b0;
          wbs++;
          wb_busy = 1;
          while (got < LW) begin
            if (m_wb_valid) begin
              lmem[rq_line*LW + got] = m_wb_data;
              got++;
              started = 1'b1;
              wb_done_cyc = cyc;
            end else if (started) begin
              wb_gap_err++;
            end
            if (got < LW) @(negedge clk);
          end
          wb_busy = 0;
        end
      end
    end
  end

  // one access beat; starts at a falling edge, returns at the falling edge after acceptance
  task automatic xfer(input bit wr, input int line, input int word, input logic [31:0] d,
                      input logic [3:0] be, input bit last,
                      output int stalls, output logic [31:0] rd, output bit rv);
    t_valid = 1'b1; t_write = wr; t_waddr = 30'(line*LW + word);
    t_wdata = d; t_be = be; t_last = last;
    stalls = 0;
    #1;
    while (!t_ready && stalls < 1000) begin
      @(negedge clk); #1; stalls++;
    end
    @(negedge clk);
    rv = t_rvalid; rd = t_rdata;
    if (wr)
      for (int b = 0; b < 4; b++)
        if (be[b]) exp_mem[line*LW + word][8*b +: 8] = d[8*b +: 8];
  endtask

  task automatic idle(input int n);
    t_valid = 1'b0; t_last = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_store(input int target);
    int n = 0;
    while ((wbs < target || wb_busy != 0) && n < 500) begin
      @(negedge clk); n++;
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic int line_mismatch(input int line);
    int m = 0;
    for (int i = 0; i < LW; i++) if (lmem[line*LW + i] !== exp_mem[line*LW + i]) m++;
    return m;
  endfunction

  task automatic t_reset();
    chk(t_ready == 1'b0,    "R1 t_ready",    32'(t_ready), 0);
    chk(t_rvalid == 1'b0,   "R1 t_rvalid",   32'(t_rvalid), 0);
    chk(m_req == 1'b0,      "R1 m_req",      32'(m_req), 0);
    chk(m_wb_valid == 1'b0, "R1 m_wb_valid", 32'(m_wb_valid), 0);
  endtask

  task automatic t_read_burst();
    int s; logic [31:0] rd; bit rv; int f0, w0;
    f0 = fills; w0 = wbs;
    xfer(0, 1, 5, 0, 4'h0, 0, s, rd, rv);
    chk(s > GNT_DLY, "R4 read miss stalls", 32'(s), GNT_DLY + 1);
    chk(rv && rd == exp_mem[1*LW + 5], "R2 read word 5", rd, exp_mem[1*LW + 5]);
    chk(fills == f0 + 1, "R2 one fetch", 32'(fills), 32'(f0 + 1));
    chk(last_fill_line == 1, "R2 fetch line address", 32'(last_fill_line), 1);
    xfer(0, 1, 31, 0, 4'h0, 0, s, rd, rv);
    chk(s == 0, "R5 hit no wait", 32'(s), 0);
    chk(rv && rd == exp_mem[1*LW + 31], "R3 word 31", rd, exp_mem[1*LW + 31]);
    xfer(0, 1, 0, 0, 4'h0, 0, s, rd, rv);
    chk(s == 0 && rd == exp_mem[1*LW], "R3 word 0", rd, exp_mem[1*LW]);
    xfer(0, 1, 6, 0, 4'h0, 1, s, rd, rv);
    chk(s == 0 && rd == exp_mem[1*LW + 6], "R5 hit word 6", rd, exp_mem[1*LW + 6]);
    chk(fills == f0 + 1, "R5 no extra fetch", 32'(fills), 32'(f0 + 1));
    idle(60);
    chk(wbs == w0, "R9 read-only not stored", 32'(wbs), 32'(w0));
    xfer(0, 1, 2, 0, 4'h0, 1, s, rd, rv);
    chk(fills == f0 + 2 && rd == exp_mem[1*LW + 2], "R8 refetch after end", 32'(fills), 32'(f0 + 2));
    idle(60);
    chk(wbs == w0, "R9 second read burst not stored", 32'(wbs), 32'(w0));
  endtask

  task automatic t_write_burst();
    int s; logic [31:0] rd; bit rv; int f0, w0;
    f0 = fills; w0 = wbs;
    xfer(1, 2, 0, 32'h1111_1111, 4'hF, 0, s, rd, rv);
    chk(s > GNT_DLY && fills == f0 + 1, "R6 write fetches first", 32'(fills), 32'(f0 + 1));
    xfer(1, 2, 1, 32'hAABB_CCDD, 4'b0101, 0, s, rd, rv);
    chk(s == 0, "R5 write hit no wait", 32'(s), 0);
    xfer(1, 2, 2, 32'hDEAD_BEEF, 4'b0000, 0, s, rd, rv);
    xfer(0, 2, 1, 0, 4'h0, 0, s, rd, rv);
    chk(rv && rd == exp_mem[2*LW + 1], "R12 read merged word", rd, exp_mem[2*LW + 1]);
    xfer(1, 2, 31, 32'h7700_0000, 4'b1000, 1, s, rd, rv);
    idle(1);
    wait_store(w0 + 1);
    chk(wbs == w0 + 1, "R7 one store", 32'(wbs), 32'(w0 + 1));
    chk(wb_gap_err == 0, "R7 consecutive beats", 32'(wb_gap_err), 0);
    chk(line_mismatch(2) == 0, "R6 merged line in memory", 32'(line_mismatch(2)), 0);
    chk(fills == f0 + 1, "R6 single fetch for burst", 32'(fills), 32'(f0 + 1));
  endtask

  task automatic t_cross_line();
    int s; logic [31:0] rd; bit rv; int w0;
    w0 = wbs;
    xfer(1, 3, 30, 32'h0303_0303, 4'hF, 0, s, rd, rv);
    xfer(1, 3, 31, 32'h3131_3131, 4'b0011, 0, s, rd, rv);
    xfer(1, 4, 0, 32'h4040_4040, 4'b1100, 0, s, rd, rv);
    chk(wbs == w0 + 1, "R10 old line stored", 32'(wbs), 32'(w0 + 1));
    chk(fill_req_cyc > wb_done_cyc, "R10 store before fetch", 32'(fill_req_cyc), 32'(wb_done_cyc + 1));
    chk(line_mismatch(3) == 0, "R10 old line content", 32'(line_mismatch(3)), 0);
    xfer(1, 4, 1, 32'h4141_4141, 4'hF, 1, s, rd, rv);
    idle(1);
    wait_store(w0 + 2);
    chk(line_mismatch(4) == 0, "R7 new line content", 32'(line_mismatch(4)), 0);
    chk(wb_gap_err == 0, "R7 consecutive beats again", 32'(wb_gap_err), 0);
  endtask

  initial begin
    for (int i = 0; i < NLINES*LW; i++) begin
      lmem[i]    = 32'h1000_0000 + 32'(i) * 32'h0001_0203;
      exp_mem[i] = lmem[i];
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_burst();
    t_write_burst();
    t_cross_line();
    idle(5);
    chk(req_hold_err == 0, "R11 request held until grant", 32'(req_hold_err), 0);
    chk(rdy_fill_err == 0, "R4 no ready during fill", 32'(rdy_fill_err), 0);
    summary();
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    summary();
  end

endmodule